// File: doc/BRIEF.md
# Word-to-Byte Mailbox Between a Core and a Host

This block joins a processor core that moves 24-bit words to an external host that moves 8-bit bytes. Each direction has one word of buffering. Core to host: the core writes a transmit word. When the three host-side receive byte lanes are free, the word is copied into them as a high, a middle and a low byte. Host to core: the host writes the same three lanes from its side. Its write to the low lane completes a word, and that word is copied into the core's receive register once the register is empty.

Each direction uses two flags: an empty flag on the sending side and a full flag on the receiving side. A word moves only when the sending side holds one (its empty flag is clear) and the receiving side is free (its full flag is clear). Each side can enable interrupt requests. The host also owns one flag bit that the core can poll, for example to end a download early. The host port is a 3-bit address with single-cycle read and write strobes. Host reads are combinational. Each strobe has its side effects exactly once.

Top module: `word_mailbox`

## Requirements
- R1: After reset: core status reads 8'h02, with core transmit-empty (bit 1) set and core receive-full (bit 0) and host flag (bit 3) clear. Host status (address 1) reads 8'h02, with host transmit-empty (bit 1) set and host receive-full (bit 0) clear. Host control (address 0) reads 8'h00. All three interrupt outputs are low.
- R2: A `core_wr_tx` pulse clears core status bit 1 at that clock edge.
- R3: When core status bit 1 and host status bit 0 are both 0, the next edge copies the transmit word into the host byte lanes. Address 5 reads bits 23:16, address 6 reads bits 15:8 and address 7 reads bits 7:0. The same edge sets host status bit 0 and core status bit 1.
- R4: A host read strobe at address 7 clears host status bit 0. Reads at addresses 5 and 6 leave it set.
- R5: While host status bit 0 is 1, a written core word stays in the transmit register, and the host lanes keep the previous word. The held word moves one edge after the low-lane read clears host status bit 0.
- R6: `host_irq` is high exactly when host control bit 0 (receive-request enable) and host status bit 0 are both 1.
- R7: `core_tx_irq` is high exactly when core control bit 1 and core status bit 1 are both 1. `core_rx_irq` is high exactly when core control bit 0 and core status bit 0 are both 1.
- R8: A host write at address 7 clears host status bit 1, having completed the word from the lanes at addresses 5, 6 and 7. When core status bit 0 is 0, the next edge copies the word to `core_rx_data`, sets core status bit 0 and sets host status bit 1 again.
- R9: A `core_rd_rx` pulse clears core status bit 0. A host word waiting behind a full receive register moves on the edge after that clear.
- R10: Host control bit 3 is the host flag and appears as core status bit 3 after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_wr_tx | input | 1 | Core write strobe for the transmit word |
| core_wdata | input | 24 | Core transmit word |
| core_rd_rx | input | 1 | Core read strobe for the receive word |
| core_rx_data | output | 24 | Core receive word |
| core_ctl_we | input | 1 | Core control write strobe |
| core_ctl_wdata | input | 2 | Bit 0 receive interrupt enable, bit 1 transmit interrupt enable |
| core_status | output | 8 | Bit 0 receive full, bit 1 transmit empty, bit 3 host flag |
| core_tx_irq | output | 1 | Core transmit interrupt request |
| core_rx_irq | output | 1 | Core receive interrupt request |
| host_addr | input | 3 | Host register select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_irq | output | 1 | Host receive interrupt request |

## Verification
Both directions are driven with a walking one across all 24 bit positions. This shows that each bit lands in the correct lane and at the correct offset, and that no two lanes are swapped. A series of dense arithmetic words follows; these catch lane bits that are stuck or shorted, which a single set bit cannot. Back-to-back words sent against a receiver that is still full show the difference between a correct hold-until-empty handshake and one that overwrites or drops a word. All four combinations of each interrupt enable, taken with each flag state, separate a correct AND of enable and flag from a flag that leaks through on its own.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_WORD_W    = 24;
  localparam int MB_BYTE_W    = 8;
  localparam int MB_ADDR_W    = 3;
  localparam int MB_STAT_W    = 8;
  localparam int MB_LANE_BASE = 5;

  // host register map (lane order is behaviour: base is high byte)
  localparam logic [MB_ADDR_W-1:0] HA_CTRL = 3'd0;
  localparam logic [MB_ADDR_W-1:0] HA_STAT = 3'd1;

  // host control bit positions
  localparam int HC_RREQ  = 0;
  localparam int HC_HFLAG = 3;
  // core status bit positions
  localparam int CS_RXFULL = 0;
  localparam int CS_TXEMPTY = 1;
  localparam int CS_HFLAG  = 3;

  // byte lane extraction, lane 0 = most significant byte
  function automatic logic [MB_BYTE_W-1:0] lane_byte(
      input logic [MB_WORD_W-1:0] w, input int lane);
    int lanes;
    lanes = MB_WORD_W / MB_BYTE_W;
    return w[(lanes-1-lane)*MB_BYTE_W +: MB_BYTE_W];
  endfunction

  // bit offset of a lane inside the word
  function automatic int lane_lsb(input int lane);
    int lanes;
    lanes = MB_WORD_W / MB_BYTE_W;
    return (lanes - 1 - lane) * MB_BYTE_W;
  endfunction
endpackage

// File: rtl/mbox_c2h_path.sv
module mbox_c2h_path #(
  parameter int WORD_W = mbox_pkg::MB_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_low,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_empty,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              move
);
  logic [WORD_W-1:0] txq, rxq;
  logic              te_q, rf_q;

  assign move     = !te_q && !rf_q;
  assign tx_word  = txq;
  assign tx_empty = te_q;
  assign rx_word  = rxq;
  assign rx_full  = rf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txq  <= '0;
      rxq  <= '0;
      te_q <= 1'b1;
      rf_q <= 1'b0;
    end else begin
      if (move) begin
        rxq  <= txq;
        rf_q <= 1'b1;
        te_q <= 1'b1;
      end else if (rd_low) begin
        rf_q <= 1'b0;
      end
      // a fresh core write wins over the refill of the empty flag
      if (wr_tx) begin
        txq  <= wdata;
        te_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbox_h2c_path.sv
module mbox_h2c_path #(
  parameter int WORD_W = mbox_pkg::MB_WORD_W,
  parameter int BYTE_W = mbox_pkg::MB_BYTE_W,
  localparam int LANES = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              core_rd,
  output logic [WORD_W-1:0] stage_word,
  output logic              tx_empty,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              move
);
  logic [WORD_W-1:0] rxq;
  logic              te_q, rf_q;
  logic              complete;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          lane_q <= '0;
      else if (lane_we[l]) lane_q <= wbyte;
    end
    assign stage_word[mbox_pkg::lane_lsb(l) +: BYTE_W] = lane_q;
  end

  // the last (least significant) lane closes a word
  assign complete = lane_we[LANES-1];
  assign move     = !te_q && !rf_q;
  assign tx_empty = te_q;
  assign rx_word  = rxq;
  assign rx_full  = rf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq  <= '0;
      te_q <= 1'b1;
      rf_q <= 1'b0;
    end else begin
      if (move) begin
        rxq  <= stage_word;
        rf_q <= 1'b1;
        te_q <= 1'b1;
      end else if (core_rd) begin
        rf_q <= 1'b0;
      end
      if (complete) te_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port #(
  parameter int WORD_W = mbox_pkg::MB_WORD_W,
  parameter int BYTE_W = mbox_pkg::MB_BYTE_W,
  parameter int ADDR_W = mbox_pkg::MB_ADDR_W,
  localparam int LANES = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_full,
  input  logic              tx_empty,
  output logic [BYTE_W-1:0] rdata,
  output logic              rreq_en,
  output logic              hflag,
  output logic              low_read,
  output logic [LANES-1:0]  lane_we
);
  import mbox_pkg::*;

  logic [LANES-1:0] lane_hit;
  logic             ctrl_wr;

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    assign lane_hit[l] = (addr == ADDR_W'(MB_LANE_BASE + l));
    assign lane_we[l]  = wr && lane_hit[l];
  end

  assign ctrl_wr  = wr && (addr == HA_CTRL);
  assign low_read = rd && lane_hit[LANES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rreq_en <= 1'b0;
      hflag   <= 1'b0;
    end else if (ctrl_wr) begin
      rreq_en <= wdata[HC_RREQ];
      hflag   <= wdata[HC_HFLAG];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == HA_CTRL) begin
      rdata[HC_RREQ]  = rreq_en;
      rdata[HC_HFLAG] = hflag;
    end else if (addr == HA_STAT) begin
      rdata[0] = rx_full;
      rdata[1] = tx_empty;
    end
    for (int l = 0; l < LANES; l++) begin
      if (lane_hit[l]) rdata = lane_byte(rx_word, l);
    end
  end
endmodule

// File: rtl/word_mailbox.sv
module word_mailbox #(
  parameter int WORD_W = mbox_pkg::MB_WORD_W,
  parameter int BYTE_W = mbox_pkg::MB_BYTE_W,
  parameter int ADDR_W = mbox_pkg::MB_ADDR_W,
  parameter int STAT_W = mbox_pkg::MB_STAT_W,
  localparam int LANES = WORD_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wr_tx,
  input  logic [WORD_W-1:0] core_wdata,
  input  logic              core_rd_rx,
  output logic [WORD_W-1:0] core_rx_data,
  input  logic              core_ctl_we,
  input  logic [1:0]        core_ctl_wdata,
  output logic [STAT_W-1:0] core_status,
  output logic              core_tx_irq,
  output logic              core_rx_irq,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_irq
);
  import mbox_pkg::*;

  // named internal events, visible to the bound checker
  logic              c2h_move, h2c_move, host_low_read;
  logic [WORD_W-1:0] c2h_tx_word, c2h_rx_word, h2c_stage;
  logic              c2h_tx_empty, c2h_rx_full, h2c_tx_empty, h2c_rx_full;
  logic [LANES-1:0]  lane_we;
  logic              rreq_en, hflag;
  logic              rx_ie, tx_ie;

  mbox_c2h_path #(.WORD_W(WORD_W)) u_c2h (
    .clk(clk), .rst_n(rst_n),
    .wr_tx(core_wr_tx), .wdata(core_wdata), .rd_low(host_low_read),
    .tx_word(c2h_tx_word), .tx_empty(c2h_tx_empty),
    .rx_word(c2h_rx_word), .rx_full(c2h_rx_full), .move(c2h_move)
  );

  mbox_h2c_path #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_h2c (
    .clk(clk), .rst_n(rst_n),
    .lane_we(lane_we), .wbyte(host_wdata), .core_rd(core_rd_rx),
    .stage_word(h2c_stage), .tx_empty(h2c_tx_empty),
    .rx_word(core_rx_data), .rx_full(h2c_rx_full), .move(h2c_move)
  );

  mbox_host_port #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .addr(host_addr), .rd(host_rd), .wr(host_wr), .wdata(host_wdata),
    .rx_word(c2h_rx_word), .rx_full(c2h_rx_full), .tx_empty(h2c_tx_empty),
    .rdata(host_rdata), .rreq_en(rreq_en), .hflag(hflag),
    .low_read(host_low_read), .lane_we(lane_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (core_ctl_we) begin
      rx_ie <= core_ctl_wdata[0];
      tx_ie <= core_ctl_wdata[1];
    end
  end

  always_comb begin
    core_status             = '0;
    core_status[CS_RXFULL]  = h2c_rx_full;
    core_status[CS_TXEMPTY] = c2h_tx_empty;
    core_status[CS_HFLAG]   = hflag;
  end

  assign core_tx_irq = tx_ie && c2h_tx_empty;
  assign core_rx_irq = rx_ie && h2c_rx_full;
  assign host_irq    = rreq_en && c2h_rx_full;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int WORD_W = mbox_pkg::MB_WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_wr_tx,
  input logic              core_rd_rx,
  input logic              core_rx_full,
  input logic              core_tx_empty,
  input logic [WORD_W-1:0] core_rx_data,
  input logic              core_tx_irq,
  input logic              core_rx_irq,
  input logic              host_irq,
  input logic              c2h_move,
  input logic              h2c_move,
  input logic              host_low_read,
  input logic              c2h_rx_full,
  input logic [WORD_W-1:0] c2h_tx_word,
  input logic [WORD_W-1:0] c2h_rx_word,
  input logic [WORD_W-1:0] h2c_stage
);
  assert_tx_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_tx |=> !core_tx_empty);

  assert_word_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c2h_move |=> (c2h_rx_full && c2h_rx_word == $past(c2h_tx_word)));

  assert_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_move && !core_wr_tx) |=> core_tx_empty);

  assert_low_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_low_read && c2h_rx_full) |=> !c2h_rx_full);

  assert_rxdf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!c2h_move && !host_low_read) |=> $stable(c2h_rx_full));

  assert_hreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> c2h_rx_full);

  assert_core_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_irq |-> core_rx_full) and (core_tx_irq |-> core_tx_empty));

  assert_h2c_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h2c_move |=> (core_rx_full && core_rx_data == $past(h2c_stage)));

  assert_core_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_rx && core_rx_full) |=> !core_rx_full);
endmodule

bind word_mailbox mbox_checker #(.WORD_W(WORD_W)) u_mbox_chk (
  .clk(clk), .rst_n(rst_n),
  .core_wr_tx(core_wr_tx), .core_rd_rx(core_rd_rx),
  .core_rx_full(core_status[0]), .core_tx_empty(core_status[1]),
  .core_rx_data(core_rx_data),
  .core_tx_irq(core_tx_irq), .core_rx_irq(core_rx_irq), .host_irq(host_irq),
  .c2h_move(c2h_move), .h2c_move(h2c_move), .host_low_read(host_low_read),
  .c2h_rx_full(c2h_rx_full), .c2h_tx_word(c2h_tx_word),
  .c2h_rx_word(c2h_rx_word), .h2c_stage(h2c_stage)
);

// File: tb/tb_word_mailbox.sv
module tb_word_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_wr_tx = 1'b0;
  logic [23:0] core_wdata = '0;
  logic        core_rd_rx = 1'b0;
  logic [23:0] core_rx_data;
  logic        core_ctl_we = 1'b0;
  logic [1:0]  core_ctl_wdata = '0;
  logic [7:0]  core_status;
  logic        core_tx_irq, core_rx_irq;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  word_mailbox dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    step();
    host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    step();
    host_wr = 1'b0;
  endtask

  task automatic core_write(input logic [23:0] w);
    core_wr_tx = 1'b1; core_wdata = w;
    step();
    core_wr_tx = 1'b0;
  endtask

  task automatic core_read();
    core_rd_rx = 1'b1;
    step();
    core_rd_rx = 1'b0;
  endtask

  task automatic core_ctl(input logic [1:0] v);
    core_ctl_we = 1'b1; core_ctl_wdata = v;
    step();
    core_ctl_we = 1'b0;
  endtask

  function automatic logic [23:0] pattern(input int k);
    if (k < 24) return 24'(1) << k;
    return 24'((k - 24) * 32'h1A2B3C + 32'h5A5) ^ 24'hC3C3C3;
  endfunction

  // core to host: write, transfer, read three bytes
  task automatic c2h_word(input logic [23:0] w);
    logic [7:0] d;
    core_write(w);
    chk("R2 tx-empty cleared", 32'(core_status[1]), 0);
    step();
    chk("R3 tx-empty refilled", 32'(core_status[1]), 1);
    host_read(3'd1, d);
    chk("R3 host rx-full set", 32'(d[0]), 1);
    host_read(3'd5, d); chk("R3 high byte", 32'(d), 32'(w[23:16]));
    host_read(3'd6, d); chk("R3 mid byte", 32'(d), 32'(w[15:8]));
    host_read(3'd1, d);
    chk("R4 rx-full kept after hi/mid", 32'(d[0]), 1);
    host_read(3'd7, d); chk("R3 low byte", 32'(d), 32'(w[7:0]));
    host_read(3'd1, d);
    chk("R4 rx-full cleared by low read", 32'(d[0]), 0);
  endtask

  // host to core: three byte writes, transfer, core read
  task automatic h2c_word(input logic [23:0] w);
    logic [7:0] d;
    host_write(3'd5, w[23:16]);
    host_write(3'd6, w[15:8]);
    host_write(3'd7, w[7:0]);
    #1 d = host_rdata;
    host_addr = 3'd1;
    #1 chk("R8 host tx-empty cleared", 32'(host_rdata[1]), 0);
    step();
    chk("R8 core rx-full set", 32'(core_status[0]), 1);
    chk("R8 core rx word", 32'(core_rx_data), 32'(w));
    host_addr = 3'd1;
    #1 chk("R8 host tx-empty refilled", 32'(host_rdata[1]), 1);
    core_read();
    chk("R9 core rx-full cleared", 32'(core_status[0]), 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    logic [23:0] w1, w2;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 core status", 32'(core_status), 32'h02);
    host_read(3'd1, d); chk("R1 host status", 32'(d), 32'h02);
    host_read(3'd0, d); chk("R1 host control", 32'(d), 32'h00);
    chk("R1 irqs", {29'b0, core_tx_irq, core_rx_irq, host_irq}, 0);

    // R2 R3 R4 sweep core to host
    for (int k = 0; k < 40; k++) c2h_word(pattern(k));
    c2h_word(24'hFFFFFF);
    c2h_word(24'h000000);

    // R8 R9 sweep host to core
    for (int k = 0; k < 40; k++) h2c_word(pattern(k));

    // R5 word held while host lanes are full
    w1 = 24'hA1B2C3; w2 = 24'h5D6E7F;
    core_write(w1); step();
    core_write(w2);
    repeat (3) step();
    chk("R5 second word held", 32'(core_status[1]), 0);
    host_read(3'd5, d); chk("R5 lanes keep first word", 32'(d), 32'h A1);
    host_read(3'd7, d); chk("R5 low of first word", 32'(d), 32'hC3);
    chk("R5 still held one cycle", 32'(core_status[1]), 0);
    step();
    chk("R5 moved after clear", 32'(core_status[1]), 1);
    host_read(3'd5, d); chk("R5 high of second word", 32'(d), 32'h5D);
    host_read(3'd6, d); chk("R5 mid of second word", 32'(d), 32'h6E);
    host_read(3'd7, d); chk("R5 low of second word", 32'(d), 32'h7F);

    // R6 host irq over enable x flag
    for (int e = 0; e < 2; e++) begin
      host_write(3'd0, 8'(e));
      chk("R6 irq with lanes empty", 32'(host_irq), 0);
      core_write(24'h123456); step();
      chk("R6 irq with lanes full", 32'(host_irq), 32'(e));
      host_read(3'd7, d);
      chk("R6 irq after low read", 32'(host_irq), 0);
    end
    host_write(3'd0, 8'h00);

    // R7 core irqs over enable combos x flag states
    for (int e = 0; e < 4; e++) begin
      core_ctl(2'(e));
      chk("R7 tx irq when empty", 32'(core_tx_irq), 32'(e >> 1));
      chk("R7 rx irq when empty", 32'(core_rx_irq), 0);
      core_write(24'h0F0F0F);
      chk("R7 tx irq when occupied", 32'(core_tx_irq), 0);
      step();
      host_read(3'd7, d);
      host_write(3'd5, 8'h11); host_write(3'd6, 8'h22); host_write(3'd7, 8'h33);
      step();
      chk("R7 rx irq when full", 32'(core_rx_irq), 32'(e & 1));
      core_read();
      chk("R7 rx irq after read", 32'(core_rx_irq), 0);
    end
    core_ctl(2'b00);

    // R9 pending host word waits for core read
    host_write(3'd5, 8'h01); host_write(3'd6, 8'h02); host_write(3'd7, 8'h03);
    step();
    host_write(3'd5, 8'h04); host_write(3'd6, 8'h05); host_write(3'd7, 8'h06);
    repeat (2) step();
    chk("R9 first word kept", 32'(core_rx_data), 32'h010203);
    host_addr = 3'd1;
    #1 chk("R9 second word pending", 32'(host_rdata[1]), 0);
    core_read();
    chk("R9 rx-full cleared", 32'(core_status[0]), 0);
    step();
    chk("R9 pending word moved", 32'(core_rx_data), 32'h040506);
    chk("R9 rx-full set again", 32'(core_status[0]), 1);
    core_read();

    // R10 host flag
    host_write(3'd0, 8'h08);
    chk("R10 flag seen by core", 32'(core_status[3]), 1);
    host_read(3'd0, d); chk("R10 flag read back", 32'(d), 32'h08);
    host_write(3'd0, 8'h00);
    chk("R10 flag cleared", 32'(core_status[3]), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule